// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block takes a freshly powered SD-bus card to the transfer state without processor help. It does not drive the CMD wire itself. Each step hands a command descriptor (index, 32-bit argument, response class) to a separate command engine and waits until that engine reports completion, with or without error, together with the first 32-bit response word. From those words the sequencer decides what kind of card is attached, captures its relative address, selects it, and then reports a ready result with a fixed 512-byte data block length.

Identification first tries the newer interface-condition handshake. If the card does not echo the check pattern, the sequencer falls back to the older operating-condition loop. If that loop also fails, it tries the multimedia-card operating-condition command. The operating-condition polling loops are bounded by a retry parameter, so a card that stays busy cannot stall the block.

Top module: `sd_ident_seq`

## Requirements
- R1: After reset, `req_valid`, `ready`, `fail` and `busy` are 0 and `card_type`, `rca` and `blk_len` are 0. A `start` pulse while idle, ready or failed clears the results. The cycle after that pulse, the first request is index 0 with argument 0 and response class 0 (none).
- R2: A request is held with unchanged index, argument and class while `req_valid` is high and `req_ready` is low. After acceptance (`req_valid` and `req_ready` both high), no new request appears until `cmd_done` has been seen.
- R3: The second request is index 8 with argument 0x000001A5 and class 1 (48-bit). The newer path is taken only if that command completes without error and response bits [7:0] equal 0xA5.
- R4: On the newer path the block repeats index 55 (argument 0) followed by index 41 with argument 0x40E00000, while both complete without error and response bit 31 is 0. When bit 31 is 1, `card_type` becomes 3 (high capacity) if bit 30 is set, otherwise 2 (standard capacity).
- R5: If index 0 errors, or index 8 errors, or the echo does not match, the loop runs with index 41 argument 0x00E00000. Success gives `card_type` 2.
- R6: If that older loop fails (command error or retry limit), index 1 with argument 0 is sent. Success gives `card_type` 1 (MMC). Failure ends in `fail` with `card_type` 0.
- R7: Each polling loop sends index 41 at most MAX_OPC_TRIES times. Reaching that limit while still busy counts as a failed loop: it ends in `fail` on the newer path and goes to index 1 on the older path.
- R8: Once a card type is known, index 2 (class 2, 136-bit) is sent, then index 3 (class 1). `rca` takes response bits [31:16] of index 3.
- R9: Index 7 is then sent with argument {rca, 16'h0} and class 3 (48-bit with busy). `ready` rises on the cycle after the edge where `xfer_done` is sampled high.
- R10: An error on the newer-path index 55 or 41, or on index 2, 3 or 7, ends in `fail` with `card_type` 0 and `rca` 0.
- R11: While `ready` is high, `blk_len` equals 512 and `card_type` is nonzero. `ready` or `fail` holds until the next `start`.
- R12: A `start` pulse while `busy` is ignored: the running sequence continues and index 0 is not reissued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin identification (strobe) |
| req_valid | output | 1 | Command request pending |
| req_ready | input | 1 | Command engine accepts the request |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_rlen | output | 2 | Response class: 0 none, 1 48-bit, 2 136-bit, 3 48-bit busy |
| cmd_done | input | 1 | Engine finished the accepted command |
| cmd_err | input | 1 | Error or timeout, valid with `cmd_done` |
| resp_word | input | 32 | First response word, valid with `cmd_done` |
| xfer_done | input | 1 | Transfer-complete indication after select |
| card_type | output | 2 | 0 none, 1 MMC, 2 standard capacity, 3 high capacity |
| rca | output | 16 | Captured relative card address |
| ready | output | 1 | Card selected and ready |
| fail | output | 1 | Identification failed |
| busy | output | 1 | Sequence in progress |
| blk_len | output | $clog2(BLOCK_BYTES+1) (10) | Data block length, 512 when ready |

## Verification
A request shows up one cycle after `start`. Each completion is taken on the edge where `cmd_done` is high, and the next request is visible one cycle later. `ready` follows `xfer_done` by exactly one edge. The bench drives all inputs on falling edges and samples on falling edges, so every check reads a value that is due at that point. Acceptance is delayed by zero to two cycles to check that the request holds, and completion latency varies. The xfer check reads `ready` low on the falling edge where `xfer_done` is raised and high on the next falling edge. Scenarios cover every busy count on both sides of the retry limit and every fallback route, and the card type, address and command counts for each run are computed in the bench.

// File: rtl/sdid_pkg.sv
// Shared types and constants for the SD identification sequencer.
// Assumes: the command engine interprets rsp_class_e as its response length.
package sdid_pkg;

    typedef enum logic [1:0] {
        CARD_NONE = 2'd0,
        CARD_MMC  = 2'd1,
        CARD_SDSC = 2'd2,
        CARD_SDHC = 2'd3
    } card_kind_e;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'd0,
        RSP_SHORT      = 2'd1,
        RSP_LONG       = 2'd2,
        RSP_SHORT_BUSY = 2'd3
    } rsp_class_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET_CARD,
        ST_PROBE_IF,
        ST_V2_APP,
        ST_V2_OPC,
        ST_V1_APP,
        ST_V1_OPC,
        ST_MMC_OPC,
        ST_GET_CID,
        ST_GET_RCA,
        ST_SELECT,
        ST_WAIT_XFER,
        ST_DONE,
        ST_FAIL
    } step_e;

    localparam logic [31:0] IF_PROBE_ARG = 32'h0000_01A5;
    localparam logic [7:0]  IF_ECHO      = 8'hA5;
    localparam logic [31:0] OPC_ARG_HC   = 32'h40E0_0000;
    localparam logic [31:0] OPC_ARG_SC   = 32'h00E0_0000;

endpackage

// File: rtl/sdid_cmd_rom.sv
// Maps the current sequencer step to the command descriptor to issue.
// Assumes: step and rca are register outputs, so the descriptor is stable
// for as long as the step does not change.
module sdid_cmd_rom
    import sdid_pkg::*;
(
    input  step_e       step,
    input  logic [15:0] rca,
    output logic        is_cmd,
    output logic [5:0]  index,
    output logic [31:0] arg,
    output rsp_class_e  rsp
);

    // Decode one descriptor per command-issuing step.
    always_comb begin
        is_cmd = 1'b1;
        index  = 6'd0;
        arg    = 32'h0;
        rsp    = RSP_NONE;
        case (step)
            ST_RESET_CARD: begin
                index = 6'd0;
            end
            ST_PROBE_IF: begin
                index = 6'd8;
                arg   = IF_PROBE_ARG;
                rsp   = RSP_SHORT;
            end
            ST_V2_APP, ST_V1_APP: begin
                index = 6'd55;
                rsp   = RSP_SHORT;
            end
            ST_V2_OPC: begin
                index = 6'd41;
                arg   = OPC_ARG_HC;
                rsp   = RSP_SHORT;
            end
            ST_V1_OPC: begin
                index = 6'd41;
                arg   = OPC_ARG_SC;
                rsp   = RSP_SHORT;
            end
            ST_MMC_OPC: begin
                index = 6'd1;
                rsp   = RSP_SHORT;
            end
            ST_GET_CID: begin
                index = 6'd2;
                rsp   = RSP_LONG;
            end
            ST_GET_RCA: begin
                index = 6'd3;
                rsp   = RSP_SHORT;
            end
            ST_SELECT: begin
                index = 6'd7;
                arg   = {rca, 16'h0000};
                rsp   = RSP_SHORT_BUSY;
            end
            default: begin
                is_cmd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sdid_resp_eval.sv
// Extracts the fields the sequencer decides on from a 32-bit response word.
// Assumes: the word is only meaningful in the cycle cmd_done is high.
module sdid_resp_eval
    import sdid_pkg::*;
(
    input  logic [31:0] word,
    output logic        echo_ok,
    output logic        ocr_up,
    output logic        ocr_hc,
    output logic [15:0] rca_field
);

    logic unused_mid;

    // Field extraction for echo check, power-up status, capacity and address.
    always_comb begin
        echo_ok    = (word[7:0] == IF_ECHO);
        ocr_up     = word[31];
        ocr_hc     = word[30];
        rca_field  = word[31:16];
        unused_mid = ^word[15:8];
    end

endmodule

// File: rtl/sdid_retry_ctr.sv
// Counts busy replies to the operating-condition command within one loop.
// Assumes: clear is held while the sequence is before either loop, and
// bump is one cycle per busy reply.
module sdid_retry_ctr #(
    parameter int MAX_TRIES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last_try
);

    localparam int CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES - 1);

    logic [CW-1:0] cnt_q;

    // Attempt counter, saturating at the final permitted attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (bump && !last_try) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_try = (cnt_q == LIMIT);

    AST_TRIES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bump && !last_try |=> cnt_q != '0); // R7

endmodule

// File: rtl/sd_ident_seq.sv
// SD card identification sequencer: card reset, interface probe, operating
// condition polling with fallbacks, address capture and card select.
// Assumes: the command engine raises cmd_done exactly once per accepted
// request, with cmd_err and resp_word valid in that cycle; xfer_done pulses
// after the select command's busy phase ends.
module sd_ident_seq
    import sdid_pkg::*;
#(
    parameter int MAX_OPC_TRIES = 1000,
    parameter int BLOCK_BYTES   = 512,
    localparam int BLKLEN_W     = $clog2(BLOCK_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [5:0]          req_index,
    output logic [31:0]         req_arg,
    output logic [1:0]          req_rlen,
    input  logic                cmd_done,
    input  logic                cmd_err,
    input  logic [31:0]         resp_word,
    input  logic                xfer_done,
    output logic [1:0]          card_type,
    output logic [15:0]         rca,
    output logic                ready,
    output logic                fail,
    output logic                busy,
    output logic [BLKLEN_W-1:0] blk_len
);

    step_e       step_q, step_d;
    logic        pend_q;
    card_kind_e  kind_q, kind_d;
    logic [15:0] rca_q;
    logic        load_rca;

    logic        is_cmd;
    logic [5:0]  rom_index;
    logic [31:0] rom_arg;
    rsp_class_e  rom_rsp;

    logic        echo_ok, ocr_up, ocr_hc;
    logic [15:0] rca_field;

    logic        fin, accept, opc_step, cnt_clear, cnt_bump, last_try;

    sdid_cmd_rom u_rom (
        .step   (step_q),
        .rca    (rca_q),
        .is_cmd (is_cmd),
        .index  (rom_index),
        .arg    (rom_arg),
        .rsp    (rom_rsp)
    );

    sdid_resp_eval u_eval (
        .word      (resp_word),
        .echo_ok   (echo_ok),
        .ocr_up    (ocr_up),
        .ocr_hc    (ocr_hc),
        .rca_field (rca_field)
    );

    sdid_retry_ctr #(.MAX_TRIES(MAX_OPC_TRIES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .bump     (cnt_bump),
        .last_try (last_try)
    );

    // Handshake qualifiers and retry-counter control.
    always_comb begin
        fin       = pend_q && cmd_done;
        accept    = req_valid && req_ready;
        opc_step  = (step_q == ST_V2_OPC) || (step_q == ST_V1_OPC);
        cnt_clear = (step_q == ST_RESET_CARD) || (step_q == ST_PROBE_IF);
        cnt_bump  = fin && opc_step && !cmd_err && !ocr_up;
    end

    // Next step and card kind, taken when a command completes.
    always_comb begin
        step_d   = step_q;
        kind_d   = kind_q;
        load_rca = 1'b0;
        case (step_q)
            ST_RESET_CARD: step_d = cmd_err ? ST_V1_APP : ST_PROBE_IF;
            ST_PROBE_IF:   step_d = (!cmd_err && echo_ok) ? ST_V2_APP : ST_V1_APP;
            ST_V2_APP:     step_d = cmd_err ? ST_FAIL : ST_V2_OPC;
            ST_V2_OPC: begin
                if (cmd_err) begin
                    step_d = ST_FAIL;
                end else if (ocr_up) begin
                    step_d = ST_GET_CID;
                    kind_d = ocr_hc ? CARD_SDHC : CARD_SDSC;
                end else begin
                    step_d = last_try ? ST_FAIL : ST_V2_APP;
                end
            end
            ST_V1_APP:     step_d = cmd_err ? ST_MMC_OPC : ST_V1_OPC;
            ST_V1_OPC: begin
                if (cmd_err) begin
                    step_d = ST_MMC_OPC;
                end else if (ocr_up) begin
                    step_d = ST_GET_CID;
                    kind_d = CARD_SDSC;
                end else begin
                    step_d = last_try ? ST_MMC_OPC : ST_V1_APP;
                end
            end
            ST_MMC_OPC: begin
                step_d = cmd_err ? ST_FAIL : ST_GET_CID;
                kind_d = CARD_MMC;
            end
            ST_GET_CID:    step_d = cmd_err ? ST_FAIL : ST_GET_RCA;
            ST_GET_RCA: begin
                step_d   = cmd_err ? ST_FAIL : ST_SELECT;
                load_rca = !cmd_err;
            end
            ST_SELECT:     step_d = cmd_err ? ST_FAIL : ST_WAIT_XFER;
            default:       step_d = step_q;
        endcase
    end

    // Sequencer state, request phase, and captured results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            pend_q <= 1'b0;
            kind_q <= CARD_NONE;
            rca_q  <= 16'h0;
        end else begin
            case (step_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        step_q <= ST_RESET_CARD;
                        pend_q <= 1'b0;
                        kind_q <= CARD_NONE;
                        rca_q  <= 16'h0;
                    end
                end
                ST_WAIT_XFER: begin
                    if (xfer_done) begin
                        step_q <= ST_DONE;
                    end
                end
                default: begin
                    if (!pend_q) begin
                        if (accept) begin
                            pend_q <= 1'b1;
                        end
                    end else if (cmd_done) begin
                        pend_q <= 1'b0;
                        step_q <= step_d;
                        if (step_d == ST_FAIL) begin
                            kind_q <= CARD_NONE;
                            rca_q  <= 16'h0;
                        end else begin
                            kind_q <= kind_d;
                            if (load_rca) begin
                                rca_q <= rca_field;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Port-level outputs.
    always_comb begin
        req_valid = is_cmd && !pend_q;
        req_index = rom_index;
        req_arg   = rom_arg;
        req_rlen  = rom_rsp;
        card_type = kind_q;
        rca       = rca_q;
        ready     = (step_q == ST_DONE);
        fail      = (step_q == ST_FAIL);
        busy      = (step_q != ST_IDLE) && (step_q != ST_DONE) && (step_q != ST_FAIL);
        blk_len   = ready ? BLKLEN_W'(BLOCK_BYTES) : '0;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_index)
                                    && $stable(req_arg) && $stable(req_rlen)); // R2
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R2
    AST_SELECT_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_index == 6'd7 |-> req_arg[31:16] == rca
                                           && req_arg[15:0] == 16'h0 && req_rlen == 2'd3); // R9
    AST_READY_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(xfer_done)); // R9
    AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> card_type == 2'd0 && rca == 16'h0); // R10
    AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> blk_len == BLKLEN_W'(BLOCK_BYTES) && card_type != 2'd0); // R11
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && step_q != ST_RESET_CARD |=> step_q != ST_RESET_CARD); // R12
    AST_CAP_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        fin && opc_step && !cmd_err && !ocr_up && last_try
        |=> step_q == ST_FAIL || step_q == ST_MMC_OPC); // R7

endmodule

// File: tb/sd_ident_seq_bench.sv
module sd_ident_seq_bench;

    localparam int MAXT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid, req_ready;
    logic [5:0]  req_index;
    logic [31:0] req_arg;
    logic [1:0]  req_rlen;
    logic        cmd_done, cmd_err, xfer_done;
    logic [31:0] resp_word;
    logic [1:0]  card_type;
    logic [15:0] rca;
    logic        ready, fail, busy;
    logic [9:0]  blk_len;

    int errors = 0;
    int checks = 0;

    // scenario settings
    logic        s_c0e, s_c8e, s_hc, s_v1e, s_mmc, s_cide, s_sele, s_v2exp;
    logic [7:0]  s_echo;
    logic [15:0] s_rca;
    int          s_v2b, s_v1b;
    int          n_cmd0, n_v2, n_v1, n_cmd1, n_cmd;

    always #5 clk = ~clk;

    sd_ident_seq #(.MAX_OPC_TRIES(MAXT)) u_sd_ident_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
        .req_arg(req_arg), .req_rlen(req_rlen), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .resp_word(resp_word), .xfer_done(xfer_done),
        .card_type(card_type), .rca(rca), .ready(ready), .fail(fail),
        .busy(busy), .blk_len(blk_len)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Command engine model
    logic [5:0]  e_idx;
    logic [31:0] e_arg, e_rsp;
    logic [1:0]  e_cls;
    logic        e_err, e_up;
    initial begin
        req_ready = 0; cmd_done = 0; cmd_err = 0; resp_word = 0; xfer_done = 0;
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                e_idx = req_index; e_arg = req_arg; e_cls = req_rlen;
                for (int w = 0; w < n_cmd % 3; w++) begin
                    @(negedge clk);
                    chk("R2 hold", {req_valid, req_rlen, req_index, 23'h0},
                        {1'b1, e_cls, e_idx, 23'h0});
                    chk("R2 hold arg", req_arg, e_arg);
                end
                req_ready = 1;
                @(negedge clk);
                req_ready = 0;
                chk("R2 one outstanding", 32'(req_valid), 0);
                n_cmd++;
                e_err = 0; e_rsp = 32'h0;
                case (e_idx)
                    6'd0: begin
                        n_cmd0++;
                        chk("R1 idx0 arg", e_arg, 0); chk("R1 idx0 cls", 32'(e_cls), 0);
                        e_err = s_c0e;
                    end
                    6'd8: begin
                        chk("R3 idx8 arg", e_arg, 32'h1A5); chk("R3 idx8 cls", 32'(e_cls), 1);
                        e_err = s_c8e; e_rsp = {24'h0, s_echo};
                    end
                    6'd55: chk("R4 idx55 arg", e_arg, 0);
                    6'd41: begin
                        chk("R4 R5 idx41 arg", e_arg, s_v2exp ? 32'h40E00000 : 32'h00E00000);
                        if (e_arg[30]) begin
                            e_up = (n_v2 >= s_v2b); n_v2++;
                            e_rsp = {e_up, e_up & s_hc, 30'h0};
                        end else begin
                            e_up = (n_v1 >= s_v1b); n_v1++;
                            e_err = s_v1e; e_rsp = {e_up, 31'h0};
                        end
                    end
                    6'd1: begin
                        n_cmd1++; chk("R6 idx1 arg", e_arg, 0);
                        e_err = !s_mmc;
                    end
                    6'd2: begin
                        chk("R8 idx2 cls", 32'(e_cls), 2);
                        e_err = s_cide; e_rsp = 32'hDEAD_BEEF;
                    end
                    6'd3: begin
                        chk("R8 idx3 cls", 32'(e_cls), 1);
                        e_rsp = {s_rca, 16'h0123};
                    end
                    6'd7: begin
                        chk("R9 idx7 arg", e_arg, {s_rca, 16'h0});
                        chk("R9 idx7 cls", 32'(e_cls), 3);
                        e_err = s_sele;
                    end
                    default: chk("R2 known index", 32'(e_idx), 32'hFFFF);
                endcase
                if (n_cmd % 2 == 1) @(negedge clk);
                cmd_done = 1; cmd_err = e_err; resp_word = e_rsp;
                @(negedge clk);
                cmd_done = 0; cmd_err = 0; resp_word = 0;
                if (e_idx == 6'd7 && !e_err) begin
                    repeat (n_cmd % 3) @(negedge clk);
                    xfer_done = 1;
                    chk("R9 ready before xfer", 32'(ready), 0);
                    @(negedge clk);
                    xfer_done = 0;
                    chk("R9 ready after xfer", 32'(ready), 1);
                end
            end
        end
    end

    task automatic run(input logic c0e, c8e, input logic [7:0] echo, input int v2b,
                       input logic hc, input int v1b, input logic v1e, mmc, cide, sele,
                       input logic [15:0] rv, input logic twice);
        int  e_v2, e_v1, e_c1, kind;
        logic found, ok, v2;
        s_c0e = c0e; s_c8e = c8e; s_echo = echo; s_v2b = v2b; s_hc = hc; s_v1b = v1b;
        s_v1e = v1e; s_mmc = mmc; s_cide = cide; s_sele = sele; s_rca = rv;
        n_cmd0 = 0; n_v2 = 0; n_v1 = 0; n_cmd1 = 0;
        v2 = !c0e && !c8e && echo == 8'hA5;
        s_v2exp = v2;
        e_v2 = 0; e_v1 = 0; e_c1 = 0; found = 0; kind = 0;
        if (v2) begin
            e_v2 = (v2b + 1 < MAXT) ? v2b + 1 : MAXT;
            found = (v2b < MAXT); kind = hc ? 3 : 2;
        end else begin
            if (v1e) e_v1 = 1;
            else begin
                e_v1 = (v1b + 1 < MAXT) ? v1b + 1 : MAXT;
                found = (v1b < MAXT); kind = 2;
            end
            if (!found) begin e_c1 = 1; found = mmc; kind = 1; end
        end
        ok = found && !cide && !sele;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R1 first request", {req_valid, ready, fail, req_rlen, req_index},
            {1'b1, 1'b0, 1'b0, 2'd0, 6'd0});
        chk("R1 first arg", req_arg, 0);
        chk("R1 cleared results", {card_type, rca}, 0);
        if (twice) begin
            repeat (3) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
        end
        for (int i = 0; i < 3000 && !(ready || fail); i++) @(negedge clk);
        chk("R11 ready", 32'(ready), 32'(ok));
        chk("R10 fail", 32'(fail), 32'(!ok));
        chk("R4 R5 R6 card_type", 32'(card_type), ok ? kind : 0);
        chk("R8 R10 rca", 32'(rca), ok ? 32'(rv) : 0);
        chk("R11 blk_len", 32'(blk_len), ok ? 512 : 0);
        chk("R7 newer-path tries", n_v2, e_v2);
        chk("R7 older-path tries", n_v1, e_v1);
        chk("R6 idx1 count", n_cmd1, e_c1);
        chk("R12 idx0 count", n_cmd0, 1);
        repeat (2) @(negedge clk);
        chk("R11 result held", {30'h0, ready, fail}, {30'h0, ok, !ok});
    endtask

    initial begin
        n_cmd = 0; s_v2exp = 1; s_rca = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset state", {req_valid, ready, fail, busy, card_type, rca, blk_len}, 0);
        for (int b = 0; b < 6; b++)
            for (int h = 0; h < 2; h++)
                run(0, 0, 8'hA5, b, h[0], 0, 0, 0, 0, 0, 16'(16'h1000 + b * 2 + h), 0);
        for (int b = 0; b < 5; b++)
            run(0, 0, 8'h5A, 0, 0, b, 0, 0, 0, 0, 16'(16'h2200 + b), 0);
        run(0, 0, 8'h5A, 0, 0, 9, 0, 1, 0, 0, 16'h3301, 0);  // R6 cap then MMC
        run(0, 1, 8'hA5, 0, 0, 1, 0, 0, 0, 0, 16'h3302, 0);  // R5 probe error
        run(1, 0, 8'hA5, 0, 0, 0, 0, 0, 0, 0, 16'h3303, 0);  // R5 reset error
        run(0, 0, 8'h00, 0, 0, 0, 1, 1, 0, 0, 16'h3304, 0);  // R6 MMC
        run(0, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 16'h3305, 0);  // R6 no card
        run(0, 0, 8'hA5, 1, 1, 0, 0, 0, 1, 0, 16'h3306, 0);  // R10 CID error
        run(0, 0, 8'hA5, 0, 0, 0, 0, 0, 0, 1, 16'h3307, 0);  // R10 select error
        run(0, 0, 8'hA5, 1, 0, 0, 0, 0, 0, 0, 16'h3308, 1);  // R12 start while busy
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule